// File: doc/BRIEF.md
# Masked Coincidence Final Trigger

This block takes the fold trigger outputs of several detector layers and decides when enough of them have fired together to call an event. Each layer input is brought into the system clock domain and its rising edge opens a coincidence window of programmable length. A per-input mask removes noisy layers from the decision. The number of unmasked open windows is compared against a programmable fold threshold. When the count first reaches the threshold, a one-cycle final trigger pulse is produced.

The final trigger raises a service request towards the readout host. The request stays set until the host acknowledges it. A separate logic trigger pulse is forwarded only when no request was already pending, so the acquisition side never sees a second event before the first is read out. Every fold level (one or more layers, two or more, and so on) has its own saturating rate scaler. A wider saturating scaler counts forwarded logic triggers. On every final trigger, vetoed or not, the set of contributing inputs and the fold levels reached are captured into a snapshot register. The scalers and the snapshot are read through a simple address-and-data port, and a clear strobe zeroes all scalers.

Top module: `coinc_final_trig`

## Requirements
- R1: The final trigger output `ft_o` is high for exactly one cycle. For inputs that rise together, it is high in the fourth clock cycle after the first edge that samples the last rising input.
- R2: An input whose bit in `mask_i` is 1 is excluded: it contributes to no fold level, no scaler and no snapshot bit.
- R3: A rising input stays counted for `win_i`+1 cycles. Two inputs whose rises are driven d cycles apart coincide when d <= `win_i` and do not coincide when d = `win_i`+1.
- R4: A final trigger is produced when the count of unmasked open windows rises from below `fold_i` to at least `fold_i`. A `fold_i` of 0 disables final triggers.
- R5: `req_o` is set by every final trigger and held until a cycle with `ack_i` high. A final trigger in the same cycle as `ack_i` leaves it set.
- R6: `lto_o` pulses together with `ft_o` only when `req_o` was low in the cycle before the final trigger. Otherwise the logic trigger is vetoed.
- R7: The scaler at read address f (0 <= f < N_IN) counts rising edges of the condition "at least f+1 unmasked windows open".
- R8: The scaler at read address N_IN counts forwarded logic triggers.
- R9: All scalers stop at their all-ones value instead of wrapping.
- R10: A cycle with `clr_i` high zeroes every scaler and leaves the snapshot unchanged.
- R11: Read address N_IN+1 returns the snapshot of the last final trigger. Bits [N_IN-1:0] hold the unmasked inputs with open windows. Bits [2*N_IN-1:N_IN] hold the fold levels reached as a thermometer code (bit N_IN+f set when at least f+1 inputs were open). The snapshot is rewritten on vetoed triggers too.
- R12: After reset all outputs are low and every read address returns zero.
- R13: An input held high produces no further window after its first rise, so a held input causes no repeated final triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| layer_i | input | N_IN | Layer fold trigger inputs, asynchronous |
| mask_i | input | N_IN | 1 excludes the input from coincidence |
| fold_i | input | clog2(N_IN+1) | Minimum number of coincident layers; 0 disables |
| win_i | input | WIN_W | Coincidence window length minus one, in cycles |
| ack_i | input | 1 | Acknowledge, clears the service request |
| clr_i | input | 1 | Clear all scalers |
| rd_addr_i | input | clog2(N_IN+2) | Read address: fold scalers, logic trigger scaler, snapshot |
| rd_data_o | output | max(LTO_W, CMB_W, 2*N_IN) | Read data, zero-extended |
| ft_o | output | 1 | Final trigger pulse |
| lto_o | output | 1 | Logic trigger pulse, vetoed while a request is pending |
| req_o | output | 1 | Service request to the readout host |

## Verification
A window counter left running too long or cut short shows up at the ports within one event. The final trigger then lands in a different cycle, or is missing or extra, when two inputs are staggered by exactly the window length or one more. A request flag that is set or cleared wrongly is seen at the next trigger, where `lto_o` does or does not pulse against the expected pattern. A scaler or snapshot that updates on the wrong condition is seen on the next readback after each scenario. Saturation faults appear only once the counters are driven past full scale, which the run does with narrow scaler widths.

// File: rtl/cft_pkg.sv
package cft_pkg;

    localparam int unsigned CFT_MAX_IN = 32;

    // number of set bits in a vector of up to CFT_MAX_IN inputs
    function automatic int unsigned ones(input logic [CFT_MAX_IN-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < CFT_MAX_IN; i++) begin
            if (v[i]) n++;
        end
        return n;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cft_edge_sync.sv
// Two-stage synchronizer plus one history stage; emits a one-cycle rise pulse.
module cft_edge_sync #(
    parameter int unsigned N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] raw_i,
    output logic [N_IN-1:0] rise_o
);

    typedef struct packed {
        logic [N_IN-1:0] meta;
        logic [N_IN-1:0] sync;
        logic [N_IN-1:0] hist;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.sync = st_q.meta;
        st_d.hist = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync & ~st_q.hist;

endmodule

// File: rtl/cft_window.sv
// Per-input window stretcher: a rise loads win_i+1, the counter runs down to zero.
module cft_window #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  rise_i,
    input  logic [WIN_W-1:0] win_i,
    output logic [N_IN-1:0]  open_o
);

    localparam int unsigned CW = WIN_W + 1;

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (rise_i[g])          cnt_d = CW'(win_i) + CW'(1);
            else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign open_o[g] = (cnt_q != '0);
    end

endmodule

// File: rtl/cft_coinc.sv
// Masked coincidence count, fold-level thermometer and rising-edge detection.
module cft_coinc
    import cft_pkg::*;
#(
    parameter int unsigned N_IN = 4,
    localparam int unsigned FW  = $clog2(N_IN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] open_i,
    input  logic [N_IN-1:0] mask_i,
    input  logic [FW-1:0]   fold_i,
    output logic [N_IN-1:0] hits_o,
    output logic [N_IN-1:0] level_o,
    output logic [N_IN-1:0] level_rise_o,
    output logic            ft_o
);

    typedef struct packed {
        logic            trig;
        logic [N_IN-1:0] level;
    } coin_st_t;

    coin_st_t st_d, st_q;

    logic [CFT_MAX_IN-1:0] hits_ext;
    int unsigned           n_open;
    logic [N_IN-1:0]       level_w;
    logic                  trig_w;

    assign hits_o = open_i & ~mask_i;

    always_comb begin
        hits_ext             = '0;
        hits_ext[N_IN-1:0]   = hits_o;
        n_open               = ones(hits_ext);
    end

    for (genvar f = 0; f < N_IN; f++) begin : g_level
        assign level_w[f] = (n_open >= 32'(f + 1));
    end

    assign trig_w = (fold_i != '0) && (n_open >= 32'(fold_i));

    always_comb begin
        st_d       = st_q;
        st_d.trig  = trig_w;
        st_d.level = level_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o      = level_w;
    assign level_rise_o = level_w & ~st_q.level;
    assign ft_o         = trig_w & ~st_q.trig;

endmodule

// File: rtl/cft_scalers.sv
// Saturating rate counters: one per fold level plus one for forwarded triggers.
module cft_scalers #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned CMB_W = 16,
    parameter int unsigned LTO_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic [N_IN-1:0]            level_rise_i,
    input  logic                       lto_fire_i,
    output logic [N_IN-1:0][CMB_W-1:0] cmb_cnt_o,
    output logic [LTO_W-1:0]           lto_cnt_o
);

    typedef struct packed {
        logic [N_IN-1:0][CMB_W-1:0] cmb;
        logic [LTO_W-1:0]           lto;
    } scl_st_t;

    scl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_IN; i++) begin
            if (clr_i)
                st_d.cmb[i] = '0;
            else if (level_rise_i[i] && (st_q.cmb[i] != '1))
                st_d.cmb[i] = st_q.cmb[i] + CMB_W'(1);
        end
        if (clr_i)
            st_d.lto = '0;
        else if (lto_fire_i && (st_q.lto != '1))
            st_d.lto = st_q.lto + LTO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmb_cnt_o = st_q.cmb;
    assign lto_cnt_o = st_q.lto;

endmodule

// File: rtl/coinc_final_trig.sv
module coinc_final_trig
    import cft_pkg::*;
#(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned WIN_W = 3,
    parameter int unsigned CMB_W = 16,
    parameter int unsigned LTO_W = 24,
    localparam int unsigned FW   = $clog2(N_IN + 1),
    localparam int unsigned AW   = $clog2(N_IN + 2),
    localparam int unsigned RD_W = max3(LTO_W, CMB_W, 2 * N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  layer_i,
    input  logic [N_IN-1:0]  mask_i,
    input  logic [FW-1:0]    fold_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             ack_i,
    input  logic             clr_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [RD_W-1:0]  rd_data_o,
    output logic             ft_o,
    output logic             lto_o,
    output logic             req_o
);

    typedef struct packed {
        logic            ft;
        logic            lto;
        logic            req;
        logic [N_IN-1:0] snap_hits;
        logic [N_IN-1:0] snap_level;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_IN-1:0]            rise_w;
    logic [N_IN-1:0]            open_w;
    logic [N_IN-1:0]            hits_w;
    logic [N_IN-1:0]            level_w;
    logic [N_IN-1:0]            level_rise_w;
    logic                       ft_w;
    logic                       lto_fire_w;
    logic [N_IN-1:0][CMB_W-1:0] cmb_cnt_w;
    logic [LTO_W-1:0]           lto_cnt_w;
    logic [N_IN-1:0]            snap_hits_w;

    cft_edge_sync #(.N_IN(N_IN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (layer_i),
        .rise_o (rise_w)
    );

    cft_window #(.N_IN(N_IN), .WIN_W(WIN_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise_w),
        .win_i  (win_i),
        .open_o (open_w)
    );

    cft_coinc #(.N_IN(N_IN)) u_coinc (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_i       (open_w),
        .mask_i       (mask_i),
        .fold_i       (fold_i),
        .hits_o       (hits_w),
        .level_o      (level_w),
        .level_rise_o (level_rise_w),
        .ft_o         (ft_w)
    );

    assign lto_fire_w = ft_w & ~st_q.req;

    cft_scalers #(.N_IN(N_IN), .CMB_W(CMB_W), .LTO_W(LTO_W)) u_scl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .level_rise_i (level_rise_w),
        .lto_fire_i   (lto_fire_w),
        .cmb_cnt_o    (cmb_cnt_w),
        .lto_cnt_o    (lto_cnt_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ft  = ft_w;
        st_d.lto = lto_fire_w;
        st_d.req = ft_w | (st_q.req & ~ack_i);
        if (ft_w) begin
            st_d.snap_hits  = hits_w;
            st_d.snap_level = level_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_hits_w = st_q.snap_hits;

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (rd_addr_i == AW'(i)) rd_data_o = RD_W'(cmb_cnt_w[i]);
        end
        if (rd_addr_i == AW'(N_IN))     rd_data_o = RD_W'(lto_cnt_w);
        if (rd_addr_i == AW'(N_IN + 1)) rd_data_o = RD_W'({st_q.snap_level, snap_hits_w});
    end

    assign ft_o  = st_q.ft;
    assign lto_o = st_q.lto;
    assign req_o = st_q.req;

endmodule

// File: rtl/cft_final_trig_chk.sv
module cft_final_trig_chk #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned LTO_W = 24,
    localparam int unsigned FW   = $clog2(N_IN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ft_o,
    input logic             lto_o,
    input logic             req_o,
    input logic             ack_i,
    input logic             clr_i,
    input logic [N_IN-1:0]  mask_i,
    input logic [FW-1:0]    fold_i,
    input logic [N_IN-1:0]  snap_hits,
    input logic [LTO_W-1:0] lto_cnt
);

    p_ft_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ft_o |=> !ft_o);

    p_mask_excluded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ft_o |-> ((snap_hits & $past(mask_i)) == '0));

    p_fold_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ft_o |-> ($past(fold_i) != '0));

    p_ft_sets_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ft_o |-> req_o);

    p_req_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    p_lto_veto_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lto_o |-> (ft_o && !$past(req_o)));

    p_lto_cnt_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (lto_cnt >= $past(lto_cnt)));

    p_clr_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (lto_cnt == '0));

endmodule

bind coinc_final_trig cft_final_trig_chk #(.N_IN(N_IN), .LTO_W(LTO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ft_o      (ft_o),
    .lto_o     (lto_o),
    .req_o     (req_o),
    .ack_i     (ack_i),
    .clr_i     (clr_i),
    .mask_i    (mask_i),
    .fold_i    (fold_i),
    .snap_hits (snap_hits_w),
    .lto_cnt   (lto_cnt_w)
);

// File: tb/coinc_final_trig_test.sv
module coinc_final_trig_test;

    localparam int unsigned N     = 4;
    localparam int unsigned CMB_W = 4;
    localparam int unsigned LTO_W = 6;
    localparam int unsigned CMAX  = (1 << CMB_W) - 1;
    localparam int unsigned LMAX  = (1 << LTO_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] layer = '0;
    logic [3:0] mask = '0;
    logic [2:0] fold = 3'd2;
    logic [2:0] win = 3'd2;
    logic       ack = 1'b0;
    logic       clr = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ft, lto, req;

    coinc_final_trig #(.N_IN(N), .WIN_W(3), .CMB_W(CMB_W), .LTO_W(LTO_W)) uut (
        .clk(clk), .rst_n(rst_n), .layer_i(layer), .mask_i(mask), .fold_i(fold),
        .win_i(win), .ack_i(ack), .clr_i(clr), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .ft_o(ft), .lto_o(lto), .req_o(req)
    );

    always #10 clk = ~clk;

    typedef struct { int cyc; bit lto; } exp_t;
    exp_t q[$];

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    int ft_seen = 0;
    int ft_exp = 0;
    int exp_c[4] = '{0, 0, 0, 0};
    int exp_l = 0;
    int exp_snap = 0;
    bit req_m = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input longint act, input longint expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s act %0d exp %0d", tag, act, expv);
        end
    endtask

    // monitor: pops expected final triggers as the design emits them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (lto && !ft) check("R6 lto without ft", 1, 0);
            if (ft) begin
                ft_seen++;
                if (q.size() == 0) begin
                    check("R1 unexpected ft", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check("R1 ft cycle", cyc, e.cyc);
                    check("R6 lto with ft", lto, e.lto);
                end
            end
        end
    end

    function automatic int therm(input int peak);
        int t;
        t = 0;
        for (int f = 0; f < peak; f++) t |= (1 << f);
        return t;
    endfunction

    task automatic expect_event(input int at, input int peak, input bit exp_ft,
                                input int hits, input bit ack_same);
        for (int f = 0; f < peak; f++) if (exp_c[f] < CMAX) exp_c[f]++;
        if (exp_ft) begin
            exp_t e;
            e.cyc = at;
            e.lto = !req_m;
            q.push_back(e);
            ft_exp++;
            if (!req_m && exp_l < LMAX) exp_l++;
            req_m = 1;
            exp_snap = (therm(peak) << 4) | hits;
        end
        if (ack_same && !exp_ft) req_m = 0;
    endtask

    task automatic pulse(input logic [3:0] bits, input int peak, input bit exp_ft,
                         input int hits, input bit ack_same);
        int base;
        @(negedge clk);
        base = cyc;
        layer = bits;
        expect_event(base + 4, peak, exp_ft, hits, ack_same);
        repeat (3) @(negedge clk);
        ack = ack_same;
        @(negedge clk);
        ack = 1'b0;
        repeat (12) @(negedge clk);
        layer = '0;
        repeat (14) @(negedge clk);
    endtask

    task automatic pair(input int d, input int peak, input bit exp_ft);
        int base;
        @(negedge clk);
        base = cyc;
        layer = 4'b0001;
        repeat (d) @(negedge clk);
        layer = 4'b0011;
        expect_event(base + d + 4, peak, exp_ft, 3, 0);
        repeat (16) @(negedge clk);
        layer = '0;
        repeat (14) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        req_m = 0;
        check("R5 req cleared by ack", req, 0);
    endtask

    task automatic check_regs(input string tag);
        @(negedge clk);
        check("R0 queue drained (missed ft)", q.size(), 0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 3'(a);
            #1;
            check($sformatf("R7 fold scaler %0d %s", a, tag), rd_data, exp_c[a]);
        end
        rd_addr = 3'd4;
        #1;
        check({"R8 lto scaler ", tag}, rd_data, exp_l);
        rd_addr = 3'd5;
        #1;
        check({"R11 snapshot ", tag}, rd_data, exp_snap);
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog expired act 1 exp 0");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 ft after reset", ft, 0);
        check("R12 lto after reset", lto, 0);
        check("R12 req after reset", req, 0);
        check_regs("R12 reset");

        // R1/R4/R6: two layers together with fold 2, request idle
        pulse(4'b0011, 2, 1, 4'b0011, 0);
        check("R5 req set by ft", req, 1);
        // R6/R11: vetoed trigger still rewrites snapshot
        pulse(4'b0111, 3, 1, 4'b0111, 0);
        check("R5 req held without ack", req, 1);
        check_regs("after veto");
        do_ack();

        // R2: masked layer cannot complete the coincidence
        mask = 4'b0001;
        pulse(4'b0011, 1, 0, 0, 0);
        mask = 4'b0000;
        check("R2 req after masked pulse", req, 0);
        check_regs("R2 masked");

        // R3: window boundaries with win=2 (3 cycles)
        pair(2, 2, 1);
        do_ack();
        pair(3, 1, 0);
        check_regs("R3 window");

        // R4: fold 0 disables, fold 4 needs all layers; R5 ack same cycle as ft
        fold = 3'd0;
        pulse(4'b1111, 4, 0, 0, 0);
        fold = 3'd4;
        pulse(4'b1111, 4, 1, 4'b1111, 1);
        check("R5 set wins over ack", req, 1);
        do_ack();
        check_regs("R4 fold");
        check("R13 ft count with held inputs", ft_seen, ft_exp);

        // R10: clear zeroes scalers, snapshot kept
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < 4; i++) exp_c[i] = 0;
        exp_l = 0;
        check_regs("R10 clear");

        // R9: drive both scalers past full scale
        fold = 3'd1;
        for (int k = 0; k < 66; k++) begin
            pulse(4'b0001, 1, 1, 4'b0001, 0);
            do_ack();
        end
        check_regs("R9 saturation");
        check("R9 fold scaler 0 at full scale", exp_c[0], CMAX);
        check("R9 lto scaler at full scale", exp_l, LMAX);
        check("R13 total ft count", ft_seen, ft_exp);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule